// File: doc/BRIEF.md
# Command-Triggered I2C Master Byte Engine

This block drives an I2C bus as a master, one bus action at a time. The host places an operation code on `op_code` and pulses `trigger` for one clock. The engine then performs exactly that action and stops: a start condition, a stop condition, a repeated start, an 8-bit transmit followed by the slave's acknowledge bit, an 8-bit receive, or a single ACK or NAK bit sent back after a receive. While the action runs, `busy` is high. When it ends, `busy` drops, `status` takes a code that names the finished action, and `irq` pulses for one clock.

The bus lines are open drain. When `scl_oe` or `sda_oe` is high, the engine pulls that line low. When the output is low, the engine releases the line. The sensed levels come back on `scl_in` and `sda_in`. Bit timing comes from a free-running prescaler that divides the clock by `PRESC_DIV`. Every SCL high phase and every SCL low phase lasts `phase_ticks` prescaler ticks. A slave may stretch the clock. After the engine releases SCL, the high-phase timer does not run until the line is actually sensed high.

Between actions, the engine holds the last levels it drove on both lines. A sequence of triggered commands therefore builds complete bus transactions.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, `busy` is 0, `irq` is 0, `status` is 0, and both `scl_oe` and `sda_oe` are 0, so both lines are released.
- R2: A trigger with a valid code while `busy` is 0 makes `busy` read 1 on the next clock. `busy` stays 1 until the action completes. In the completion clock `busy` reads 0 and `irq` is high for that one clock only, which gives exactly one pulse per action.
- R3: Code 0 makes SDA fall while SCL is high and sets status 1. Code 1 ends with SDA rising while SCL is high and sets status 2. Code 2 releases SDA, raises SCL, then pulls SDA low while SCL is high, and sets status 5. No data bit ever makes SDA change while SCL is high.
- R4: Code 6 transmits `tx_data` MSB first on 8 SCL clocks. On a 9th clock the engine releases SDA. It then sets `ack_rcvd` to 1 if SDA was sensed low at the end of that high phase and to 0 otherwise, and sets status 6.
- R5: Code 3 issues 8 SCL clocks with SDA released. It samples SDA MSB first at the end of each high phase, loads the byte into `rx_data`, and sets status 3.
- R6: Code 4 issues one SCL clock with SDA held low (ACK). Code 5 issues one SCL clock with SDA released (NAK). Both set status 4.
- R7: If SCL stays low after the engine releases it, the engine keeps SCL released, the high-phase timer waits, and `busy` stays 1. No further clock edge is produced until the line is sensed high.
- R8: A trigger while `busy` is 1 is ignored. The running action finishes with its own status and its own bus activity. Code 7 is not an action: it leaves `busy` at 0 and leaves `status` and both line drives unchanged.
- R9: Without stretching, each SCL high phase lasts `phase_ticks` × `PRESC_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Operation to run on the next trigger (0 start, 1 stop, 2 repeated start, 3 receive, 4 ACK, 5 NAK, 6 transmit, 7 none) |
| trigger | input | 1 | One-clock pulse that launches `op_code` |
| tx_data | input | DATA_W | Byte to transmit, captured at the trigger |
| phase_ticks | input | PHASE_W | Prescaler ticks per SCL high or low phase |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Action in progress |
| status | output | 3 | Code of the last completed action |
| rx_data | output | DATA_W | Last received byte |
| ack_rcvd | output | 1 | 1 when the slave acknowledged the last transmitted byte |
| irq | output | 1 | One-clock completion pulse |

## Verification
The hardest situation to reach from the ports is a slave holding SCL low during a high phase. The engine's own timer is running at that moment. The check must show that no SCL edge appears, no completion occurs and `busy` stays high for an arbitrary wait. To get there, the bench models the bus as a wired-AND with an extra stretch pull-down. It asserts that pull-down while the bus is idle with SCL low. It then launches a receive and holds the pull-down for many phase lengths before releasing it. Once the line is released, the received byte must still come out intact. A second hard-to-reach situation is a trigger that arrives mid-byte. The bench fires a stop code partway through a transmit and checks that no stop condition appears on the wires.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_STOP   = 3'd1,
    OP_RSTART = 3'd2,
    OP_RX     = 3'd3,
    OP_ACK    = 3'd4,
    OP_NAK    = 3'd5,
    OP_TX     = 3'd6,
    OP_NONE   = 3'd7
  } op_e;

  localparam logic [2:0] ST_IDLE   = 3'd0;
  localparam logic [2:0] ST_START  = 3'd1;
  localparam logic [2:0] ST_STOP   = 3'd2;
  localparam logic [2:0] ST_RXFULL = 3'd3;
  localparam logic [2:0] ST_ACKED  = 3'd4;
  localparam logic [2:0] ST_RSTART = 3'd5;
  localparam logic [2:0] ST_TXDONE = 3'd6;

  function automatic logic [2:0] done_code(op_e op);
    case (op)
      OP_START:       return ST_START;
      OP_STOP:        return ST_STOP;
      OP_RSTART:      return ST_RSTART;
      OP_RX:          return ST_RXFULL;
      OP_ACK, OP_NAK: return ST_ACKED;
      OP_TX:          return ST_TXDONE;
      default:        return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == CW'(DIV - 1));
      if (cnt == CW'(DIV - 1)) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_shifter.sv
module i2c_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int PRESC_DIV = 4,
  parameter int PHASE_W   = 8,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_code,
  input  logic              trigger,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [PHASE_W-1:0] phase_ticks,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic [2:0]        status,
  output logic [DATA_W-1:0] rx_data,
  output logic              ack_rcvd,
  output logic              irq
);
  localparam int MAX_STEP = 2 * (DATA_W + 1);
  localparam int STEP_W   = $clog2(MAX_STEP + 1);

  op_e               op_q;
  logic [STEP_W-1:0] step, last_step, bit_k;
  logic [PHASE_W-1:0] cnt;
  logic              tick, scl_rel, sda_rel, cnt_done, stretched, adv, launch;
  logic              do_shift;
  logic [DATA_W-1:0] sh_q;

  i2c_tick_gen #(.DIV(PRESC_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  assign launch = !busy && trigger && (op_code != OP_NONE);

  // Per-step wanted line levels (1 = released)
  always_comb begin
    bit_k     = step >> 1;
    last_step = STEP_W'(2);
    scl_rel   = 1'b1;
    sda_rel   = 1'b1;
    case (op_q)
      OP_START: begin
        last_step = STEP_W'(1);
        scl_rel   = (step == '0);
        sda_rel   = 1'b0;
      end
      OP_STOP: begin
        last_step = STEP_W'(2);
        scl_rel   = (step != '0);
        sda_rel   = (step == STEP_W'(2));
      end
      OP_RSTART: begin
        last_step = STEP_W'(3);
        scl_rel   = (step == STEP_W'(1)) || (step == STEP_W'(2));
        sda_rel   = (step <= STEP_W'(1));
      end
      OP_TX: begin
        last_step = STEP_W'(2 * (DATA_W + 1));
        scl_rel   = step[0];
        sda_rel   = (bit_k < STEP_W'(DATA_W)) ? sh_q[DATA_W-1] : 1'b1;
      end
      OP_RX: begin
        last_step = STEP_W'(2 * DATA_W);
        scl_rel   = step[0];
        sda_rel   = 1'b1;
      end
      OP_ACK: begin
        last_step = STEP_W'(2);
        scl_rel   = step[0];
        sda_rel   = (bit_k != '0);
      end
      OP_NAK: begin
        last_step = STEP_W'(2);
        scl_rel   = step[0];
        sda_rel   = 1'b1;
      end
      default: ;
    endcase
  end

  assign cnt_done  = ({1'b0, cnt} + 1'b1) >= {1'b0, phase_ticks};
  assign stretched = scl_rel && !scl_in;
  assign adv       = busy && tick && !stretched && cnt_done;
  assign do_shift  = adv && step[0] &&
                     (((op_q == OP_TX) && (bit_k < STEP_W'(DATA_W))) || (op_q == OP_RX));

  i2c_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(launch), .load_val(tx_data),
    .shift(do_shift), .din(sda_in), .q(sh_q)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_NONE;
      busy     <= 1'b0;
      step     <= '0;
      cnt      <= '0;
      status   <= ST_IDLE;
      irq      <= 1'b0;
      rx_data  <= '0;
      ack_rcvd <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        op_q <= op_e'(op_code);
        step <= '0;
        cnt  <= '0;
      end else if (busy && tick && !stretched) begin
        if (cnt_done) begin
          cnt <= '0;
          if ((op_q == OP_TX) && step[0] && (bit_k == STEP_W'(DATA_W)))
            ack_rcvd <= !sda_in;
          if (step == last_step) begin
            busy   <= 1'b0;
            irq    <= 1'b1;
            status <= done_code(op_q);
            if (op_q == OP_RX) rx_data <= sh_q;
          end else begin
            step <= step + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // Registered open-drain drives; held between actions
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (busy) begin
      scl_oe <= !scl_rel;
      sda_oe <= !sda_rel;
    end
  end

endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] op_code,
  input logic       trigger,
  input logic       busy,
  input logic       irq,
  input logic [2:0] status,
  input logic       scl_oe,
  input logic       scl_in
);
  a_r2_busy_on_trigger: assert property (@(posedge clk) disable iff (rst)
    (!busy && trigger && op_code != 3'd7) |=> busy);

  a_r2_irq_at_completion: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && $past(busy)));

  a_r8_null_code_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && trigger && op_code == 3'd7) |=> (!busy && $stable(status) && $stable(scl_oe)));

  a_r7_stretch_no_edge: assert property (@(posedge clk) disable iff (rst)
    (busy && !scl_oe && !scl_in && $past(!scl_oe && !scl_in)) |=> (!scl_oe && !irq));

  a_r3_status_legal: assert property (@(posedge clk) disable iff (rst)
    status != 3'd7);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst(rst), .op_code(op_code), .trigger(trigger), .busy(busy),
  .irq(irq), .status(status), .scl_oe(scl_oe), .scl_in(scl_in)
);

// File: tb/i2c_cmd_master_bench.sv
module i2c_cmd_master_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_code = 3'd7;
  logic       trigger = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] phase_ticks = 8'd2;
  logic       scl_oe, sda_oe, busy, ack_rcvd, irq;
  logic [2:0] status;
  logic [7:0] rx_data;

  // bench-side bus model
  logic       stretch = 1'b0;
  logic       slave_rx = 1'b0;
  logic       slave_ack = 1'b0;
  logic [7:0] rx_pat = 8'h00;
  logic       slave_low, scl_l, sda_l;

  int tests = 0, fails = 0;
  int op_id = 0, seen_id = 0;
  int rises, falls, starts, stops, irqs, hi_cnt, last_hi;
  logic [8:0] cap;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  always #4 clk = ~clk;

  assign slave_low = slave_rx ? ((falls < 8) && !rx_pat[3'd7 - 3'(falls)])
                              : (slave_ack && (falls == 8));
  assign scl_l = !scl_oe && !stretch;
  assign sda_l = !sda_oe && !slave_low;

  i2c_cmd_master u_i2c_cmd_master (
    .clk(clk), .rst(rst), .op_code(op_code), .trigger(trigger), .tx_data(tx_data),
    .phase_ticks(phase_ticks), .scl_in(scl_l), .sda_in(sda_l),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .status(status),
    .rx_data(rx_data), .ack_rcvd(ack_rcvd), .irq(irq)
  );

  // bus monitor
  always @(negedge clk) begin
    if (op_id != seen_id) begin
      seen_id = op_id;
      rises = 0; falls = 0; starts = 0; stops = 0; irqs = 0; cap = '0;
    end else begin
      if (prev_scl && scl_l && prev_sda && !sda_l) starts++;
      if (prev_scl && scl_l && !prev_sda && sda_l) stops++;
      if (!prev_scl && scl_l) begin rises++; cap = {cap[7:0], sda_l}; end
      if (prev_scl && !scl_l) falls++;
      if (irq) irqs++;
    end
    if (scl_l) hi_cnt++;
    else begin
      if (prev_scl) last_hi = hi_cnt;
      hi_cnt = 0;
    end
    prev_scl = scl_l;
    prev_sda = sda_l;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start_op(input logic [2:0] op, input logic [7:0] d);
    op_id++;
    @(negedge clk);
    op_code = op; tx_data = d; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0; op_code = 3'd7;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0] op; logic [7:0] data; logic ack; logic [2:0] st;
    logic [1:0] nst; logic [1:0] nsp; logic [3:0] nr;
  } vec_t;

  localparam vec_t VT [10] = '{
    '{3'd0, 8'h00, 1'b0, 3'd1, 2'd1, 2'd0, 4'd0},
    '{3'd6, 8'hA5, 1'b1, 3'd6, 2'd0, 2'd0, 4'd9},
    '{3'd6, 8'h3C, 1'b0, 3'd6, 2'd0, 2'd0, 4'd9},
    '{3'd2, 8'h00, 1'b0, 3'd5, 2'd1, 2'd0, 4'd1},
    '{3'd6, 8'hA1, 1'b1, 3'd6, 2'd0, 2'd0, 4'd9},
    '{3'd3, 8'h5A, 1'b0, 3'd3, 2'd0, 2'd0, 4'd8},
    '{3'd4, 8'h00, 1'b0, 3'd4, 2'd0, 2'd0, 4'd1},
    '{3'd3, 8'hC3, 1'b0, 3'd3, 2'd0, 2'd0, 4'd8},
    '{3'd5, 8'h00, 1'b0, 3'd4, 2'd0, 2'd0, 4'd1},
    '{3'd1, 8'h00, 1'b0, 3'd2, 2'd0, 2'd1, 4'd1}
  };

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd6: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default: return "R3";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "status", status, 0);
    check("R1", "scl_oe", scl_oe, 0);
    check("R1", "sda_oe", sda_oe, 0);
    check("R1", "irq", irq, 0);

    // table walk
    foreach (VT[i]) begin
      slave_rx  = (VT[i].op == 3'd3);
      rx_pat    = VT[i].data;
      slave_ack = VT[i].ack;
      start_op(VT[i].op, VT[i].data);
      check("R2", "busy after trigger", busy, 1);
      wait_done();
      check(req_of(VT[i].op), "status", status, VT[i].st);
      check("R2", "irq pulses", irqs, 1);
      check("R3", "start conditions", starts, VT[i].nst);
      check("R3", "stop conditions", stops, VT[i].nsp);
      check(req_of(VT[i].op), "scl clocks", rises, VT[i].nr);
      case (VT[i].op)
        3'd6: begin
          check("R4", "byte on wire", cap[8:1], VT[i].data);
          check("R4", "ack_rcvd", ack_rcvd, VT[i].ack);
        end
        3'd3: check("R5", "rx_data", rx_data, VT[i].data);
        3'd4: check("R6", "ack level", cap[0], 0);
        3'd5: check("R6", "nak level", cap[0], 1);
        default: ;
      endcase
    end
    slave_rx = 1'b0; slave_ack = 1'b0;

    // R8: trigger while busy is ignored
    start_op(3'd0, 8'h00);
    wait_done();
    slave_ack = 1'b1;
    start_op(3'd6, 8'hF0);
    repeat (20) @(negedge clk);
    op_code = 3'd1; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0; op_code = 3'd7;
    wait_done();
    check("R8", "status after busy trigger", status, 6);
    check("R8", "stops during busy trigger", stops, 0);
    check("R8", "byte intact", cap[8:1], 8'hF0);
    slave_ack = 1'b0;

    // R8: code 7 has no effect
    start_op(3'd7, 8'h00);
    check("R8", "busy on null code", busy, 0);
    repeat (10) @(negedge clk);
    check("R8", "status on null code", status, 6);
    check("R8", "scl drive on null code", scl_oe, 1);

    // R7: clock stretch during a receive
    stretch = 1'b1;
    slave_rx = 1'b1; rx_pat = 8'h96;
    start_op(3'd3, 8'h00);
    repeat (120) @(negedge clk);
    check("R7", "busy while stretched", busy, 1);
    check("R7", "scl clocks while stretched", rises, 0);
    stretch = 1'b0;
    wait_done();
    check("R7", "rx_data after stretch", rx_data, 8'h96);
    check("R7", "status after stretch", status, 3);
    slave_rx = 1'b0;

    // R9: high phase length
    phase_ticks = 8'd3;
    start_op(3'd5, 8'h00);
    wait_done();
    check("R9", "high length 3 ticks", last_hi, 12);
    phase_ticks = 8'd2;
    start_op(3'd4, 8'h00);
    wait_done();
    check("R9", "high length 2 ticks", last_hi, 8);
    start_op(3'd1, 8'h00);
    wait_done();
    check("R3", "final stop", stops, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule